// File: doc/BRIEF.md
# Receive Timeout Counter Controller

This block is a 16-bit down-counter with a preload register. It has two modes. In software mode, start and stop commands drive the counter. When the count runs out it raises a counter-ready flag and reloads from the preload register, so it acts as a periodic timer.

A per-receiver timeout mode changes that behaviour. When timeout mode is on for a receiver, each character that receiver moves into its FIFO reloads the counter and restarts it. Software start and stop are then locked out. The counter halts at terminal count, so counter-ready means that no qualifying character arrived for the whole preload period. With both receivers in timeout mode, a character from either one restarts the count.

Commands arrive as a one-cycle code with a receiver index. The timing enable `tick` paces the count. Every output is registered, so each effect is visible from the clock edge after the cycle that caused it.

Top module: `rx_timeout_ctr`

## Requirements
- R1: While reset is asserted, the block clears the count, the running state, the ready flag and both timeout-mode bits to zero.
- R2: A start command (cmd_code 1) issued with no timeout mode on loads the count from the preload register and sets the running state.
- R3: Each tick while running lowers the count by one. A tick at count zero sets the ready flag. In software mode that same tick reloads the preload value and the counter keeps running.
- R4: A stop command (cmd_code 2) issued with no timeout mode on clears both the running state and the ready flag, and holds the count.
- R5: A set-timeout command (cmd_code 3, receiver index in cmd_chan) sets that receiver's mode bit (bit i of tmo_on for receiver i), stops the counter and clears the ready flag.
- R6: While any mode bit is set, start and stop commands have no effect.
- R7: A transfer strobe (rx_xfer bit i) from a receiver whose mode bit is set loads the preload value and sets the running state. A strobe from a receiver whose mode bit is clear is ignored.
- R8: In timeout mode, a tick at count zero sets the ready flag and stops the counter with the count left at zero. No further reload happens until the next qualifying strobe.
- R9: With both mode bits set, a strobe from either receiver restarts the count, so the ready flag rises only after both have been idle for the full period.
- R10: A clear-timeout command (cmd_code 4) clears only that receiver's mode bit. The count, the running state and the ready flag are kept.
- R11: A preload write changes only the preload register. The running count is unchanged until the next load.
- R12: Within one cycle, an effective command takes precedence over a transfer strobe, and a strobe takes precedence over a tick. A command that is locked out counts as no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing enable for one count step |
| cmd_code | input | 3 | Command: 0 none, 1 start, 2 stop, 3 set timeout, 4 clear timeout |
| cmd_chan | input | 1 | Receiver index for the timeout commands |
| preload_we | input | 1 | Preload register write strobe |
| preload_data | input | 16 | Preload value |
| rx_xfer | input | 2 | Per-receiver strobe for a character moved into its FIFO |
| count_val | output | 16 | Current count |
| cnt_running | output | 1 | Counter running |
| cnt_ready | output | 1 | Counter-ready flag |
| tmo_on | output | 2 | Per-receiver timeout-mode bits |

## Verification
Every result is one register away from its cause. A command, strobe, tick or preload write sampled at one rising edge shows on the outputs right after that edge. The bench changes inputs 1 ns after a rising edge and reads outputs 1 ns after the next one, so each read sees exactly one step.

The terminal-count case is due on tick number preload+1 after a load. The bench sweeps small preload values and checks that the ready flag is low on every earlier tick and high on exactly that one, in both modes.

// File: rtl/rtot_pkg.sv
package rtot_pkg;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_START   = 3'd1,
        CMD_STOP    = 3'd2,
        CMD_SET_TMO = 3'd3,
        CMD_CLR_TMO = 3'd4
    } ctl_cmd_e;

    typedef struct packed {
        logic load;          // load preload value and run
        logic halt;          // stop and clear ready
        logic tick_go;       // take one count step
        logic reload_on_tc;  // software mode: reload at terminal count
    } ctl_strobes_t;

    function automatic ctl_cmd_e decode_cmd(input logic [2:0] raw);
        case (raw)
            3'd1:    return CMD_START;
            3'd2:    return CMD_STOP;
            3'd3:    return CMD_SET_TMO;
            3'd4:    return CMD_CLR_TMO;
            default: return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rtot_cmd_decode.sv
module rtot_cmd_decode
    import rtot_pkg::*;
#(
    parameter int NRX = 2
) (
    input  logic [2:0]     cmd_code,
    input  logic [NRX-1:0] tmo_on,
    input  logic [NRX-1:0] rx_xfer,
    input  logic           tick,
    input  logic           running,
    output ctl_strobes_t   st,
    output logic           set_mode,
    output logic           clr_mode
);
    ctl_cmd_e cmd;
    logic     any_tmo;
    logic     sw_start;
    logic     sw_stop;
    logic     cmd_taken;
    logic     xfer_go;

    always_comb begin
        cmd       = decode_cmd(cmd_code);
        any_tmo   = |tmo_on;
        sw_start  = (cmd == CMD_START) && !any_tmo;
        sw_stop   = (cmd == CMD_STOP)  && !any_tmo;
        set_mode  = (cmd == CMD_SET_TMO);
        clr_mode  = (cmd == CMD_CLR_TMO);
        cmd_taken = sw_start || sw_stop || set_mode || clr_mode;
        xfer_go   = !cmd_taken && (|(rx_xfer & tmo_on));

        st.load         = sw_start || xfer_go;
        st.halt         = sw_stop || set_mode;
        st.tick_go      = !cmd_taken && !xfer_go && running && tick;
        st.reload_on_tc = !any_tmo;
    end

endmodule

// File: rtl/rtot_mode_regs.sv
module rtot_mode_regs #(
    parameter int NRX = 2,
    parameter int CHW = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           set_mode,
    input  logic           clr_mode,
    input  logic [CHW-1:0] chan,
    output logic [NRX-1:0] mode_q
);
    for (genvar i = 0; i < NRX; i++) begin : g_rx
        logic hit;
        assign hit = (chan == CHW'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q[i] <= 1'b0;
            end else if (set_mode && hit) begin
                mode_q[i] <= 1'b1;
            end else if (clr_mode && hit) begin
                mode_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rtot_down_counter.sv
module rtot_down_counter
    import rtot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_strobes_t     st,
    input  logic [CNT_W-1:0] preload,
    output logic [CNT_W-1:0] count_q,
    output logic             running_q,
    output logic             ready_q
);
    logic at_tc;
    assign at_tc = (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            running_q <= 1'b0;
            ready_q   <= 1'b0;
        end else if (st.load) begin
            count_q   <= preload;
            running_q <= 1'b1;
        end else if (st.halt) begin
            running_q <= 1'b0;
            ready_q   <= 1'b0;
        end else if (st.tick_go) begin
            if (at_tc) begin
                ready_q <= 1'b1;
                if (st.reload_on_tc) begin
                    count_q <= preload;
                end else begin
                    running_q <= 1'b0;
                end
            end else begin
                count_q <= count_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/rx_timeout_ctr.sv
module rx_timeout_ctr
    import rtot_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NRX   = 2,
    localparam int CHW  = (NRX > 1) ? $clog2(NRX) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [2:0]       cmd_code,
    input  logic [CHW-1:0]   cmd_chan,
    input  logic             preload_we,
    input  logic [CNT_W-1:0] preload_data,
    input  logic [NRX-1:0]   rx_xfer,
    output logic [CNT_W-1:0] count_val,
    output logic             cnt_running,
    output logic             cnt_ready,
    output logic [NRX-1:0]   tmo_on
);
    logic [CNT_W-1:0] preload_q;
    ctl_strobes_t     st;
    logic             set_mode;
    logic             clr_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            preload_q <= '0;
        end else if (preload_we) begin
            preload_q <= preload_data;
        end
    end

    rtot_cmd_decode #(.NRX(NRX)) u_dec (
        .cmd_code (cmd_code),
        .tmo_on   (tmo_on),
        .rx_xfer  (rx_xfer),
        .tick     (tick),
        .running  (cnt_running),
        .st       (st),
        .set_mode (set_mode),
        .clr_mode (clr_mode)
    );

    rtot_mode_regs #(.NRX(NRX), .CHW(CHW)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .set_mode (set_mode),
        .clr_mode (clr_mode),
        .chan     (cmd_chan),
        .mode_q   (tmo_on)
    );

    rtot_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .preload   (preload_q),
        .count_q   (count_val),
        .running_q (cnt_running),
        .ready_q   (cnt_ready)
    );

endmodule

// File: rtl/rx_timeout_ctr_sva.sv
module rx_timeout_ctr_sva #(
    parameter int CNT_W = 16,
    parameter int NRX   = 2,
    localparam int CHW  = (NRX > 1) ? $clog2(NRX) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [2:0]       cmd_code,
    input logic [CHW-1:0]   cmd_chan,
    input logic [NRX-1:0]   rx_xfer,
    input logic [CNT_W-1:0] preload_q,
    input logic [CNT_W-1:0] count_val,
    input logic             cnt_running,
    input logic             cnt_ready,
    input logic [NRX-1:0]   tmo_on
);
    logic quiet;
    assign quiet = (cmd_code == 3'd0) && ((rx_xfer & tmo_on) == '0);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (count_val == '0 && !cnt_running && !cnt_ready && tmo_on == '0)); // R1

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 3'd1 && tmo_on == '0) |=> (cnt_running && count_val == $past(preload_q))); // R2

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (quiet && tick && cnt_running && count_val != '0) |=> (count_val == $past(count_val) - CNT_W'(1))); // R3

    AST_READY_AT_TC: assert property (@(posedge clk) disable iff (rst)
        (quiet && tick && cnt_running && count_val == '0) |=> cnt_ready); // R3

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 3'd2 && tmo_on == '0) |=> (!cnt_running && !cnt_ready && $stable(count_val))); // R4

    AST_SET_TMO: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 3'd3) |=> (!cnt_running && !cnt_ready && tmo_on[$past(cmd_chan)])); // R5

    AST_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
        ((cmd_code == 3'd1 || cmd_code == 3'd2) && tmo_on != '0 && (rx_xfer & tmo_on) == '0 && !tick)
        |=> ($stable(cnt_running) && $stable(cnt_ready) && $stable(count_val))); // R6

    AST_XFER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 3'd0 && (rx_xfer & tmo_on) != '0) |=> (cnt_running && count_val == $past(preload_q))); // R7

    AST_TMO_HALT: assert property (@(posedge clk) disable iff (rst)
        (quiet && tmo_on != '0 && tick && cnt_running && count_val == '0) |=> (!cnt_running && count_val == '0)); // R8

    AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 3'd4) |=> ($stable(cnt_running) && $stable(cnt_ready) && $stable(count_val))); // R10

endmodule

bind rx_timeout_ctr rx_timeout_ctr_sva #(.CNT_W(CNT_W), .NRX(NRX)) u_sva (.*);

// File: tb/rx_timeout_ctr_test.sv
module rx_timeout_ctr_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [2:0]  cmd_code = 3'd0;
    logic [0:0]  cmd_chan = 1'b0;
    logic        preload_we = 1'b0;
    logic [15:0] preload_data = 16'd0;
    logic [1:0]  rx_xfer = 2'b00;
    logic [15:0] count_val;
    logic        cnt_running;
    logic        cnt_ready;
    logic [1:0]  tmo_on;

    int checks = 0;
    int errors = 0;

    localparam int NONE = 0, START = 1, STOP = 2, SETT = 3, CLRT = 4;

    always #2 clk = ~clk;

    rx_timeout_ctr uut (
        .clk(clk), .rst(rst), .tick(tick), .cmd_code(cmd_code), .cmd_chan(cmd_chan),
        .preload_we(preload_we), .preload_data(preload_data), .rx_xfer(rx_xfer),
        .count_val(count_val), .cnt_running(cnt_running), .cnt_ready(cnt_ready), .tmo_on(tmo_on)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs, outputs read 1 ns after the edge
    task automatic cyc(input int c, input int ch, input int xf, input bit tk);
        cmd_code = 3'(c);
        cmd_chan = 1'(ch);
        rx_xfer  = 2'(xf);
        tick     = tk;
        @(posedge clk);
        #1;
        cmd_code = 3'd0;
        cmd_chan = 1'b0;
        rx_xfer  = 2'b00;
        tick     = 1'b0;
    endtask

    task automatic wr(input int v);
        preload_we   = 1'b1;
        preload_data = 16'(v);
        @(posedge clk);
        #1;
        preload_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 count", int'(count_val), 0);
        chk("R1 running", int'(cnt_running), 0);
        chk("R1 ready", int'(cnt_ready), 0);
        chk("R1 mode", int'(tmo_on), 0);
        rst = 1'b0;

        // software mode sweep over preload values
        for (int p = 0; p <= 4; p++) begin
            wr(p);
            cyc(START, 0, 0, 0);
            chk("R2 count", int'(count_val), p);
            chk("R2 running", int'(cnt_running), 1);
            for (int k = 1; k <= p; k++) begin
                cyc(NONE, 0, 0, 1);
                chk("R3 count", int'(count_val), p - k);
                chk("R3 ready low", int'(cnt_ready), 0);
            end
            cyc(NONE, 0, 0, 1);
            chk("R3 ready at tc", int'(cnt_ready), 1);
            chk("R3 reload", int'(count_val), p);
            chk("R3 still running", int'(cnt_running), 1);
            cyc(STOP, 0, 0, 0);
            chk("R4 running", int'(cnt_running), 0);
            chk("R4 ready", int'(cnt_ready), 0);
            cyc(NONE, 0, 0, 1);
            cyc(NONE, 0, 0, 1);
            chk("R4 count held", int'(count_val), p);
        end

        // preload write does not disturb running count
        wr(7);
        cyc(START, 0, 0, 0);
        chk("R11 load", int'(count_val), 7);
        wr(3);
        chk("R11 count kept", int'(count_val), 7);
        cyc(NONE, 0, 0, 1);
        chk("R11 step", int'(count_val), 6);
        cyc(START, 0, 0, 1);
        chk("R12 start over tick / R11 new preload", int'(count_val), 3);
        repeat (4) cyc(NONE, 0, 0, 1);
        chk("R3 ready p3", int'(cnt_ready), 1);

        // enter timeout mode on receiver 0
        cyc(SETT, 0, 0, 0);
        chk("R5 mode", int'(tmo_on), 1);
        chk("R5 running", int'(cnt_running), 0);
        chk("R5 ready", int'(cnt_ready), 0);
        cyc(START, 0, 0, 0);
        chk("R6 start locked", int'(cnt_running), 0);
        cyc(NONE, 0, 2, 0);
        chk("R7 other rx ignored", int'(cnt_running), 0);
        chk("R7 other rx count", int'(count_val), 3);
        wr(5);
        cyc(NONE, 0, 1, 0);
        chk("R7 load", int'(count_val), 5);
        chk("R7 running", int'(cnt_running), 1);
        cyc(STOP, 0, 0, 0);
        chk("R6 stop locked", int'(cnt_running), 1);
        chk("R6 count", int'(count_val), 5);

        // timeout sweep
        for (int p = 0; p <= 3; p++) begin
            wr(p);
            cyc(SETT, 0, 0, 0);
            cyc(NONE, 0, 1, 0);
            chk("R7 load sweep", int'(count_val), p);
            for (int k = 1; k <= p; k++) begin
                cyc(NONE, 0, 0, 1);
                chk("R8 ready low", int'(cnt_ready), 0);
            end
            cyc(NONE, 0, 0, 1);
            chk("R8 ready", int'(cnt_ready), 1);
            chk("R8 halted", int'(cnt_running), 0);
            cyc(NONE, 0, 0, 1);
            cyc(NONE, 0, 0, 1);
            chk("R8 count stays zero", int'(count_val), 0);
            chk("R8 no restart", int'(cnt_running), 0);
        end

        // both receivers
        cyc(SETT, 1, 0, 0);
        chk("R9 both modes", int'(tmo_on), 3);
        chk("R5 ready cleared", int'(cnt_ready), 0);
        wr(4);
        cyc(NONE, 0, 1, 0);
        cyc(NONE, 0, 0, 1);
        cyc(NONE, 0, 0, 1);
        chk("R9 partial", int'(count_val), 2);
        cyc(NONE, 0, 2, 0);
        chk("R9 rx1 restarts", int'(count_val), 4);
        repeat (4) cyc(NONE, 0, 0, 1);
        chk("R9 not yet", int'(cnt_ready), 0);
        cyc(NONE, 0, 0, 1);
        chk("R9 timeout", int'(cnt_ready), 1);
        cyc(NONE, 0, 3, 0);
        chk("R9 both strobes", int'(count_val), 4);
        chk("R9 running", int'(cnt_running), 1);

        // precedence
        cyc(SETT, 0, 1, 1);
        chk("R12 cmd over xfer", int'(cnt_running), 0);
        chk("R12 count", int'(count_val), 4);
        cyc(NONE, 0, 1, 1);
        chk("R12 xfer over tick", int'(count_val), 4);
        cyc(NONE, 0, 0, 1);
        chk("R12 step", int'(count_val), 3);

        // leaving timeout mode keeps state
        cyc(CLRT, 0, 0, 0);
        chk("R10 mode", int'(tmo_on), 2);
        chk("R10 running", int'(cnt_running), 1);
        chk("R10 count", int'(count_val), 3);
        cyc(CLRT, 1, 0, 0);
        chk("R10 mode off", int'(tmo_on), 0);
        chk("R10 count kept", int'(count_val), 3);
        cyc(SETT, 0, 0, 0);
        wr(1);
        cyc(NONE, 0, 1, 0);
        cyc(NONE, 0, 0, 1);
        cyc(NONE, 0, 0, 1);
        chk("R8 ready p1", int'(cnt_ready), 1);
        cyc(CLRT, 0, 0, 0);
        chk("R10 ready kept", int'(cnt_ready), 1);
        chk("R10 halted kept", int'(cnt_running), 0);
        cyc(STOP, 0, 0, 0);
        chk("R4 stop after leave", int'(cnt_ready), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule